// File: doc/BRIEF.md
# One-Hot Sequencer with Upset Detection

This block is an eight-position sequencer built with one flip-flop per state. Exactly one bit is set in normal operation. Each cycle with `advance` high moves that bit one place toward bit 0. From bit 0 it wraps back to bit 7. Of the 256 codes the register can hold, only eight are legal. The other 248 cannot be reached unless something disturbs the flip-flops.

The block observes upsets but does not repair them. A test input, `injectMask`, flips chosen state bits at a clock edge so that upsets can be reproduced.

- **Parity check.** An odd-parity check over the state vector sets a sticky error flag one cycle after the vector holds an even number of ones. Every single-bit upset is caught this way.
- **Lockup indicator.** A separate indicator is high while more than one bit is set. This covers the locked-up case where several hot bits keep circulating.
- **No recovery.** There is no recovery path. A corrupted code keeps rotating until reset.

Top module: `onehot_parity_seq`

## Requirements
- R1: While `rst` is high, the next clock edge loads `stateVec` = 8'h80 (only bit 7 set) and clears `parityErr`. With that code, `lockup` is 0.
- R2: At a clock edge with `advance` = 1 and `injectMask` = 0, `stateVec` becomes its previous value rotated right by one: new bit i = old bit i+1, and new bit 7 = old bit 0. The sequence is therefore 80, 40, 20, 10, 08, 04, 02, 01, 80.
- R3: At a clock edge with `advance` = 0 and `injectMask` = 0, `stateVec` keeps its value.
- R4: At every edge out of reset, bit i of `injectMask` inverts bit i of the new state. The inversion is applied after any rotation that `advance` requests in the same cycle.
- R5: `parityErr` rises at the clock edge that follows any cycle in which `stateVec` holds an even number of ones.
- R6: Once set, `parityErr` stays at 1 until reset, even if the state returns to a code with an odd number of ones.
- R7: `lockup` is combinational. It is 1 exactly when two or more bits of `stateVec` are set.
- R8: A code with several hot bits keeps rotating under `advance` with the same number of ones, so `lockup` stays high indefinitely.
- R9: A code with three hot bits has odd parity. `parityErr` stays 0 for it while `lockup` flags it.
- R10: An upset that clears the only hot bit leaves `stateVec` = 0. That code stays 0 under `advance`, sets `parityErr`, and keeps `lockup` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step the hot bit one position this cycle |
| injectMask | input | 8 | Bits of the state to invert at this edge (upset emulation) |
| stateVec | output | 8 | Current state code |
| parityErr | output | 1 | Sticky flag: an even-parity code was seen |
| lockup | output | 1 | More than one state bit is set |

## Verification
The hardest situations to reach are the corrupted codes, because no sequence of legal steps ever leaves the eight one-hot codes.

The stimulus therefore uses `injectMask`, sometimes in the same cycle as `advance`:
- It adds a second hot bit and then keeps stepping for more than a full turn, to show the pair never merges.
- It adds two bits at once, giving a three-hot code that parity misses.
- It clears the only hot bit, producing the all-zero code.

Between these cases, reset brings the block back to a legal code. This also shows that the sticky flag is cleared only by reset.

// File: rtl/onehot_seq_pkg.sv
package onehot_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;   // rotate the state this cycle
    logic flip;   // apply the upset mask this cycle
  } seqStrobe_t;

  function automatic int unsigned countHot(input logic [31:0] vec, input int unsigned width);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < width; i++) begin
      if (vec[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/onehot_seq_datapath.sv
module onehot_seq_datapath
  import onehot_seq_pkg::*;
#(
  parameter int NUM_STATES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobe_t            strobe,
  input  logic [NUM_STATES-1:0] flipMask,
  output logic [NUM_STATES-1:0] stateVec
);

  localparam logic [NUM_STATES-1:0] RESET_CODE = {1'b1, {(NUM_STATES-1){1'b0}}};

  logic [NUM_STATES-1:0] stateQ;
  logic [NUM_STATES-1:0] rotated;
  logic [NUM_STATES-1:0] nextState;

  // Rotate toward bit 0, wrapping bit 0 into the top position
  genvar g;
  generate
    for (g = 0; g < NUM_STATES; g++) begin : g_rot
      if (g == NUM_STATES - 1) begin : g_wrap
        assign rotated[g] = stateQ[0];
      end else begin : g_shift
        assign rotated[g] = stateQ[g+1];
      end
    end
  endgenerate

  always_comb begin
    nextState = strobe.step ? rotated : stateQ;
    if (strobe.flip) nextState = nextState ^ flipMask;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= RESET_CODE;
    else     stateQ <= nextState;
  end

  assign stateVec = stateQ;

  // R8
  hot_count_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.flip |=> $countones(stateQ) == $countones($past(stateQ)));

  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.step && !strobe.flip) |=> $stable(stateQ));

  // R2
  wrap_from_low_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.flip && stateQ == {{(NUM_STATES-1){1'b0}}, 1'b1})
      |=> stateQ == RESET_CODE);

endmodule

// File: rtl/onehot_seq_control.sv
module onehot_seq_control
  import onehot_seq_pkg::*;
#(
  parameter int NUM_STATES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  advance,
  input  logic [NUM_STATES-1:0] injectMask,
  input  logic [NUM_STATES-1:0] stateVec,
  output seqStrobe_t            strobe,
  output logic                  parityErr,
  output logic                  lockup
);

  logic evenParity;
  logic errQ;
  logic [NUM_STATES-1:0] seenBefore;
  logic [NUM_STATES-1:0] seenTwice;

  always_comb begin
    strobe.step = advance;
    strobe.flip = |injectMask;
  end

  // Odd parity is the legal case; even parity means an upset
  assign evenParity = ~(^stateVec);

  // Prefix scan: seenTwice[i] is set once a second hot bit appears at or below i
  genvar g;
  generate
    for (g = 0; g < NUM_STATES; g++) begin : g_scan
      if (g == 0) begin : g_first
        assign seenBefore[g] = stateVec[g];
        assign seenTwice[g]  = 1'b0;
      end else begin : g_next
        assign seenBefore[g] = seenBefore[g-1] | stateVec[g];
        assign seenTwice[g]  = seenTwice[g-1] | (seenBefore[g-1] & stateVec[g]);
      end
    end
  endgenerate

  assign lockup = seenTwice[NUM_STATES-1];

  always_ff @(posedge clk) begin
    if (rst)             errQ <= 1'b0;
    else if (evenParity) errQ <= 1'b1;
  end

  assign parityErr = errQ;

  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    errQ |=> errQ);

  // R5
  even_detect_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(stateVec) % 2 == 0) |=> errQ);

  // R7
  lockup_multi_chk: assert property (@(posedge clk) disable iff (rst)
    lockup == ($countones(stateVec) > 1));

  // R10
  zero_no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
    (stateVec == '0) |-> !lockup);

endmodule

// File: rtl/onehot_parity_seq.sv
module onehot_parity_seq
  import onehot_seq_pkg::*;
#(
  parameter int NUM_STATES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  advance,
  input  logic [NUM_STATES-1:0] injectMask,
  output logic [NUM_STATES-1:0] stateVec,
  output logic                  parityErr,
  output logic                  lockup
);

  seqStrobe_t strobe;
  logic [NUM_STATES-1:0] stateInt;

  onehot_seq_control #(.NUM_STATES(NUM_STATES)) u_control (
    .clk        (clk),
    .rst        (rst),
    .advance    (advance),
    .injectMask (injectMask),
    .stateVec   (stateInt),
    .strobe     (strobe),
    .parityErr  (parityErr),
    .lockup     (lockup)
  );

  onehot_seq_datapath #(.NUM_STATES(NUM_STATES)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .flipMask (injectMask),
    .stateVec (stateInt)
  );

  assign stateVec = stateInt;

  // R4
  single_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (!advance && $countones(injectMask) == 1) |=>
      $countones(stateVec ^ $past(stateVec)) == 1);

endmodule

// File: tb/onehot_parity_seq_bench.sv
module onehot_parity_seq_bench;

  localparam int N = 8;

  typedef struct {
    logic [N-1:0] st;
    logic         par;
    logic         lock;
    string        req;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         advance = 1'b0;
  logic [N-1:0] injectMask = '0;
  logic [N-1:0] stateVec;
  logic         parityErr;
  logic         lockup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  expItem_t     expQ[$];
  logic [N-1:0] mState;
  logic         mPar;

  always #2.5 clk = ~clk;

  onehot_parity_seq #(.NUM_STATES(N)) u_onehot_parity_seq (
    .clk(clk), .rst(rst), .advance(advance), .injectMask(injectMask),
    .stateVec(stateVec), .parityErr(parityErr), .lockup(lockup)
  );

  function automatic int popc(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic compare(input expItem_t e);
    checks++;
    if (stateVec !== e.st || parityErr !== e.par || lockup !== e.lock) begin
      errors++;
      $display("FAIL %s: state=%h par=%b lock=%b expected state=%h par=%b lock=%b",
               e.req, stateVec, parityErr, lockup, e.st, e.par, e.lock);
    end
  endtask

  // Monitor: pops expected items one negedge after each driven edge
  always @(negedge clk) begin
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  // Driver: one clock edge with given inputs, model pushes expectation
  task automatic drive(input logic adv, input logic [N-1:0] mask, input string req);
    expItem_t e;
    logic [N-1:0] nxt;
    @(negedge clk);
    advance = adv;
    injectMask = mask;
    nxt = adv ? {mState[0], mState[N-1:1]} : mState;
    nxt = nxt ^ mask;
    mPar = mPar | (popc(mState) % 2 == 0);
    mState = nxt;
    @(posedge clk);
    e.st = mState; e.par = mPar; e.lock = (popc(mState) > 1); e.req = req;
    expQ.push_back(e);
  endtask

  task automatic doReset();
    expItem_t e;
    @(negedge clk);
    rst = 1'b1; advance = 1'b0; injectMask = '0;
    @(posedge clk);
    @(negedge clk);
    mState = 8'h80; mPar = 1'b0;
    e.st = 8'h80; e.par = 1'b0; e.lock = 1'b0; e.req = "R1";
    compare(e);
    rst = 1'b0;
  endtask

  initial begin
    mState = 8'h80; mPar = 1'b0;
    repeat (2) @(posedge clk);
    doReset();

    // R2: full turn including wrap
    for (int i = 0; i < 9; i++) drive(1'b1, '0, "R2");
    // R3: hold
    for (int i = 0; i < 3; i++) drive(1'b0, '0, "R3");
    // R4 with advance in same cycle: adds a second hot bit, R7 lockup
    drive(1'b1, 8'h04, "R4");
    // R5 parity raised next edge; R8 pair keeps rotating
    for (int i = 0; i < 11; i++) drive(1'b1, '0, "R8");
    // R6: clear the extra bit, parity flag stays
    drive(1'b0, mState & (~mState + 1'b1), "R6");
    for (int i = 0; i < 3; i++) drive(1'b1, '0, "R6");

    doReset();
    // R9: two extra bits at once, three hot, parity silent
    drive(1'b0, 8'h12, "R9");
    for (int i = 0; i < 9; i++) drive(1'b1, '0, "R9");

    doReset();
    // R10: clear the only hot bit
    drive(1'b0, 8'h80, "R10");
    for (int i = 0; i < 4; i++) drive(1'b1, '0, "R10");
    drive(1'b0, '0, "R10");

    doReset();
    // R4 without advance: single flip of low bit
    drive(1'b0, 8'h01, "R4");
    drive(1'b0, 8'h01, "R4");
    drive(1'b0, '0, "R6");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule